// File: doc/BRIEF.md
# Delta-Sigma Bitstream Decimator

This block turns the one-bit output of a delta-sigma modulator into signed 16-bit PCM samples. A programmable integer divider derives a sampling enable from the system clock; on each enable the block takes one modulator bit and feeds it into a fourth-order cascaded integrator-comb filter. After a selectable number of modulator samples (64, 128, 192 or 384), one decimated value passes through four comb stages. It is then normalised to 16 bits, multiplied by an optional extra gain and saturated. Finally it is presented with a single-cycle valid strobe for a downstream FIFO.

The sampling enable is also brought out so that the modulator can be clocked in step with the filter. Dropping the converter enable stops sampling and clears every piece of filter state. The next conversion therefore starts exactly as it would after reset.

Top module: `sd_decimator`

## Requirements
- R1: `sd_ce` pulses for one cycle once every D system clocks, where D is `clk_div`, and any `clk_div` value of 2 or less behaves as D = 3. The first pulse comes in the first cycle after `en` rises.
- R2: The bit on `sd_bit` is taken in a cycle where `sd_ce` is high, and 1 counts as +1 while 0 counts as -1.
- R3: `osr_sel` selects the decimation ratio R: code 0 gives 64, 1 gives 128, 2 gives 192 and 3 gives 384. `pcm_valid` pulses once per R sampling enables.
- R4: Codes 4 to 15 of `osr_sel` behave exactly as code 0.
- R5: In steady state, with an input whose mean is m and whose period divides R, the filter value is m·R^4. It is arithmetically shifted right by S, where S is 9, 13, 16 or 20 for R = 64, 128, 192 or 384.
- R6: The shifted value is multiplied by (2 + `gain`)/2, rounding toward minus infinity, so `gain` = 0 is unity.
- R7: The result saturates to the range -32768 to +32767.
- R8: `pcm_valid` is never high in two consecutive cycles.
- R9: While `en` is low, `sd_ce` and `pcm_valid` stay low and `pcm` is 0 from the next cycle. A sample in flight is dropped, and after `en` returns the output sequence is identical to that after reset.
- R10: `pcm` changes only in a cycle where `pcm_valid` is high, or when `en` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Converter enable; low stops sampling and clears the filter |
| clk_div | input | 8 | Sampling divider D (values of 2 or less act as 3) |
| osr_sel | input | 4 | Decimation ratio code |
| gain | input | 4 | Extra gain G, applied as (2+G)/2 |
| sd_bit | input | 1 | Modulator bitstream |
| sd_ce | output | 1 | Sampling enable, one cycle every D clocks |
| pcm | output | 16 | Signed PCM sample |
| pcm_valid | output | 1 | One-cycle strobe marking a new `pcm` |

## Verification
The clear from `en` can land in the same cycles as the comb pipeline is carrying a freshly decimated sample. The bench provokes this by dropping `en` in the cycle right after the 128th sampling enable at R = 64, when the decimation strobe has just been registered. It is judged by seeing no `pcm_valid`, a zero `pcm`, and a restarted output sequence that matches a fresh run sample for sample. The steady-state values for every ratio code, several duty patterns and several gains are computed in the bench from m·R^4, the shift and the gain factor.

// File: rtl/sd_dec_pkg.sv
package sd_dec_pkg;

  typedef enum logic [1:0] {
    RATIO_64  = 2'd0,
    RATIO_128 = 2'd1,
    RATIO_192 = 2'd2,
    RATIO_384 = 2'd3
  } ratio_e;

  // codes outside 1..3 fall back to the smallest ratio
  function automatic ratio_e ratio_decode(input logic [3:0] code);
    case (code)
      4'd1:    return RATIO_128;
      4'd2:    return RATIO_192;
      4'd3:    return RATIO_384;
      default: return RATIO_64;
    endcase
  endfunction

  function automatic int ratio_value(input ratio_e r);
    case (r)
      RATIO_128: return 128;
      RATIO_192: return 192;
      RATIO_384: return 384;
      default:   return 64;
    endcase
  endfunction

  // right shift that brings ratio^order down to out_w signed bits
  function automatic int norm_shift(input int ratio, input int order, input int out_w);
    longint gain_full;
    int     bits;
    gain_full = 1;
    for (int i = 0; i < order; i++) gain_full = gain_full * longint'(ratio);
    bits = 0;
    while ((longint'(1) << bits) < gain_full) bits++;
    return bits - (out_w - 1);
  endfunction

endpackage

// File: rtl/sd_ce_gen.sv
module sd_ce_gen #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             ce
);

  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] cnt_q, cnt_d, eff_div;

  assign eff_div = (div < MIN_V) ? MIN_V : div;
  assign ce      = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!en)     cnt_d = '0;
    else if (ce) cnt_d = eff_div - 1'b1;
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sd_cic_core.sv
module sd_cic_core #(
  parameter int ORDER = 4,
  parameter int ACC_W = 37,
  parameter int CNT_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    ce,
  input  logic                    bit_in,
  input  logic [CNT_W-1:0]        last_idx,
  output logic signed [ACC_W-1:0] comb_out,
  output logic                    comb_vld
);

  localparam logic signed [ACC_W-1:0] PLUS_ONE = ACC_W'(1);

  logic signed [ACC_W-1:0] x_in;
  logic signed [ACC_W-1:0] int_val  [ORDER];
  logic signed [ACC_W-1:0] comb_val [ORDER];
  logic                    comb_stb [ORDER];
  logic [CNT_W-1:0]        dcnt_q, dcnt_d;
  logic                    dec_q, dec_d;

  assign x_in = bit_in ? PLUS_ONE : -PLUS_ONE;

  // integrator chain, one register per stage, modular arithmetic
  for (genvar k = 0; k < ORDER; k++) begin : g_int
    logic signed [ACC_W-1:0] addend, acc_q, acc_d;
    if (k == 0) begin : g_first
      assign addend = x_in;
    end else begin : g_next
      assign addend = int_val[k-1];
    end
    always_comb begin
      acc_d = acc_q;
      if (!en)     acc_d = '0;
      else if (ce) acc_d = acc_q + addend;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end
    assign int_val[k] = acc_q;
  end

  // decimation counter
  always_comb begin
    dcnt_d = dcnt_q;
    dec_d  = 1'b0;
    if (!en) begin
      dcnt_d = '0;
    end else if (ce) begin
      if (dcnt_q >= last_idx) begin
        dcnt_d = '0;
        dec_d  = 1'b1;
      end else begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q <= '0;
      dec_q  <= 1'b0;
    end else begin
      dcnt_q <= dcnt_d;
      dec_q  <= dec_d;
    end
  end

  // comb chain, one stage per clock after the decimation strobe
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    logic signed [ACC_W-1:0] din, dly_q, dly_d, out_q, out_d;
    logic                    stb_in, vld_q, vld_d;
    if (k == 0) begin : g_first
      assign din    = int_val[ORDER-1];
      assign stb_in = dec_q;
    end else begin : g_next
      assign din    = comb_val[k-1];
      assign stb_in = comb_stb[k-1];
    end
    always_comb begin
      dly_d = dly_q;
      out_d = out_q;
      vld_d = 1'b0;
      if (!en) begin
        dly_d = '0;
        out_d = '0;
      end else if (stb_in) begin
        dly_d = din;
        out_d = din - dly_q;
        vld_d = 1'b1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q <= '0;
        out_q <= '0;
        vld_q <= 1'b0;
      end else begin
        dly_q <= dly_d;
        out_q <= out_d;
        vld_q <= vld_d;
      end
    end
    assign comb_val[k] = out_q;
    assign comb_stb[k] = vld_q;
  end

  assign comb_out = comb_val[ORDER-1];
  assign comb_vld = comb_stb[ORDER-1];

endmodule

// File: rtl/sd_out_scale.sv
module sd_out_scale #(
  parameter int ACC_W   = 37,
  parameter int OUT_W   = 16,
  parameter int GAIN_W  = 4,
  parameter int SHIFT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_data,
  input  logic [SHIFT_W-1:0]      shift,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [OUT_W-1:0] pcm,
  output logic                    pcm_vld
);

  localparam int PROD_W = ACC_W + GAIN_W + 2;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

  logic signed [ACC_W-1:0]  norm;
  logic signed [PROD_W-1:0] norm_ext, gfac, prod, half;
  logic signed [OUT_W-1:0]  sat_val, pcm_d;
  logic                     vld_d;

  assign norm     = in_data >>> shift;
  assign norm_ext = {{(PROD_W-ACC_W){norm[ACC_W-1]}}, norm};
  assign gfac     = PROD_W'(gain) + PROD_W'(2);
  assign prod     = norm_ext * gfac;
  assign half     = prod >>> 1;

  always_comb begin
    if (half > SAT_HI)      sat_val = SAT_HI[OUT_W-1:0];
    else if (half < SAT_LO) sat_val = SAT_LO[OUT_W-1:0];
    else                    sat_val = half[OUT_W-1:0];
  end

  always_comb begin
    pcm_d = pcm;
    vld_d = 1'b0;
    if (!en) begin
      pcm_d = '0;
    end else if (in_vld) begin
      pcm_d = sat_val;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm     <= '0;
      pcm_vld <= 1'b0;
    end else begin
      pcm     <= pcm_d;
      pcm_vld <= vld_d;
    end
  end

endmodule

// File: rtl/sd_decimator.sv
module sd_decimator
  import sd_dec_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int SEL_W   = 4,
  parameter int GAIN_W  = 4,
  parameter int OUT_W   = 16,
  parameter int ORDER   = 4,
  parameter int MAX_OSR = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [SEL_W-1:0]  osr_sel,
  input  logic [GAIN_W-1:0] gain,
  input  logic              sd_bit,
  output logic              sd_ce,
  output logic [OUT_W-1:0]  pcm,
  output logic              pcm_valid
);

  localparam int CNT_W   = $clog2(MAX_OSR);
  localparam int ACC_W   = 1 + ORDER * CNT_W;
  localparam int SHIFT_W = $clog2(ACC_W) + 1;
  localparam int SH_64   = norm_shift(64,  ORDER, OUT_W);
  localparam int SH_128  = norm_shift(128, ORDER, OUT_W);
  localparam int SH_192  = norm_shift(192, ORDER, OUT_W);
  localparam int SH_384  = norm_shift(384, ORDER, OUT_W);

  logic                    rst_meta_q, rst_sync_q;
  ratio_e                  ratio;
  logic [CNT_W-1:0]        last_idx;
  logic [SHIFT_W-1:0]      shift;
  logic signed [ACC_W-1:0] comb_out;
  logic                    comb_vld;
  logic signed [OUT_W-1:0] pcm_s;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign ratio    = ratio_decode(4'(osr_sel));
  assign last_idx = CNT_W'(ratio_value(ratio) - 1);

  always_comb begin
    case (ratio)
      RATIO_128: shift = SHIFT_W'(SH_128);
      RATIO_192: shift = SHIFT_W'(SH_192);
      RATIO_384: shift = SHIFT_W'(SH_384);
      default:   shift = SHIFT_W'(SH_64);
    endcase
  end

  sd_ce_gen #(
    .DIV_W   (DIV_W),
    .MIN_DIV (3)
  ) u_ce (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .en    (en),
    .div   (clk_div),
    .ce    (sd_ce)
  );

  sd_cic_core #(
    .ORDER (ORDER),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
  ) u_cic (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .en       (en),
    .ce       (sd_ce),
    .bit_in   (sd_bit),
    .last_idx (last_idx),
    .comb_out (comb_out),
    .comb_vld (comb_vld)
  );

  sd_out_scale #(
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .GAIN_W  (GAIN_W),
    .SHIFT_W (SHIFT_W)
  ) u_scale (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .en      (en),
    .in_vld  (comb_vld),
    .in_data (comb_out),
    .shift   (shift),
    .gain    (gain),
    .pcm     (pcm_s),
    .pcm_vld (pcm_valid)
  );

  assign pcm = pcm_s;

endmodule

// File: rtl/sd_decimator_chk.sv
module sd_decimator_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sd_ce,
  input logic [OUT_W-1:0] pcm,
  input logic             pcm_valid
);

  AST_CE_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !sd_ce);                                                  // R9

  AST_CE_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    sd_ce && en |=> !sd_ce);                                          // R1

  AST_VALID_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);                                        // R8

  AST_IDLE_CLEARS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pcm == '0) && !pcm_valid);                               // R9

  AST_PCM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pcm_valid && en && $past(en)) |-> $stable(pcm));                // R10

endmodule

bind sd_decimator sd_decimator_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .sd_ce     (sd_ce),
  .pcm       (pcm),
  .pcm_valid (pcm_valid)
);

// File: tb/sd_decimator_tb.sv
`timescale 1ns/100ps
module sd_decimator_tb;

  logic        clk, rst_n, en, sd_bit;
  logic [7:0]  clk_div;
  logic [3:0]  osr_sel, gain;
  logic        sd_ce, pcm_valid;
  logic [15:0] pcm;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [3:0]  pat   = 4'b1111;
  int          pidx  = 0;
  int          ce_cnt = 0;

  sd_decimator u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_div(clk_div), .osr_sel(osr_sel),
    .gain(gain), .sd_bit(sd_bit), .sd_ce(sd_ce), .pcm(pcm), .pcm_valid(pcm_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // modulator model: next pattern bit presented after each sampling enable
  initial begin
    sd_bit = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (sd_ce === 1'b1) begin
        sd_bit = pat[pidx[1:0]];
        pidx   = (pidx + 1) % 4;
        ce_cnt = ce_cnt + 1;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(195000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete (actual=hung expected=done)");
    finish_run();
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid(output logic signed [15:0] v);
    do @(negedge clk); while (pcm_valid !== 1'b1);
    v = pcm;
  endtask

  task automatic restart(input logic [3:0] code, input logic [7:0] d, input logic [3:0] p);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    osr_sel = code; clk_div = d; pat = p; gain = 4'd0;
    @(negedge clk);
    pidx = 0; ce_cnt = 0;
    en = 1'b1;
  endtask

  function automatic int ratio_of(input logic [3:0] code);
    case (code)
      4'd1: return 128;
      4'd2: return 192;
      4'd3: return 384;
      default: return 64;
    endcase
  endfunction

  function automatic int shift_of(input int r);
    case (r)
      128: return 13;
      192: return 16;
      384: return 20;
      default: return 9;
    endcase
  endfunction

  // steady state: mean (2k-4)/4 for k ones per period of 4
  function automatic longint expect_pcm(input int r, input int k, input int g);
    longint r4, v, n, p;
    r4 = longint'(r) * r * r * r;
    v  = (r4 * (2 * k - 4)) / 4;
    n  = v >>> shift_of(r);
    p  = (n * (2 + g)) >>> 1;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  logic [3:0] pats  [5] = '{4'b1111, 4'b0000, 4'b0101, 4'b0111, 4'b0001};
  int         ones  [5] = '{4, 0, 2, 3, 1};
  logic [3:0] codes [6] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd15};
  int         gains [3] = '{0, 3, 15};
  int         divs  [7] = '{0, 1, 2, 3, 4, 7, 20};

  initial begin
    logic signed [15:0] v, held;
    logic signed [15:0] ref_seq [6];
    int c5, r, npat, n, e;
    string tag;

    rst_n = 1'b0; en = 1'b0; clk_div = 8'd3; osr_sel = 4'd0; gain = 4'd0;
    repeat (4) @(negedge clk);
    chk("R9 reset pcm", pcm, 0);
    chk("R9 reset valid", pcm_valid, 0);
    chk("R9 reset sd_ce", sd_ce, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: sampling enable period
    foreach (divs[i]) begin
      restart(4'd0, 8'(divs[i]), 4'b1111);
      @(negedge clk);
      while (sd_ce !== 1'b1) @(negedge clk);
      n = 0;
      do begin @(negedge clk); n++; end while (sd_ce !== 1'b1);
      e = (divs[i] < 3) ? 3 : divs[i];
      chk($sformatf("R1 ce period div=%0d", divs[i]), n, e);
    end

    // R2..R8, R10: ratio, scaling, gain, saturation sweep
    foreach (codes[ci]) begin
      r    = ratio_of(codes[ci]);
      npat = (codes[ci] > 4'd3) ? 2 : 5;
      for (int pi = 0; pi < npat; pi++) begin
        restart(codes[ci], 8'd3, pats[pi]);
        for (int j = 0; j < 5; j++) wait_valid(v);
        c5 = ce_cnt;
        wait_valid(v);
        if (codes[ci] > 4'd3) tag = "R4 reserved code ratio";
        else                  tag = "R3 ratio";
        chk($sformatf("%s code=%0d", tag, codes[ci]), ce_cnt - c5, r);
        @(negedge clk);
        chk("R8 valid drops after one cycle", pcm_valid, 0);
        foreach (gains[gi]) begin
          gain = 4'(gains[gi]);
          wait_valid(v);
          e = int'(expect_pcm(r, ones[pi], gains[gi]));
          if (e == 32767 || e == -32768) tag = "R7 saturate";
          else if (gains[gi] != 0)       tag = "R6 gain";
          else                           tag = "R2/R5 level";
          chk($sformatf("%s code=%0d pat=%b g=%0d", tag, codes[ci], pats[pi], gains[gi]),
              longint'(v), longint'(e));
          held = v;
          repeat (3) @(negedge clk);
          chk("R10 pcm held between strobes", longint'($signed(pcm)), longint'(held));
        end
      end
    end

    // R9: disable with a sample in flight, then restart must match a fresh run
    restart(4'd0, 8'd3, 4'b0001);
    for (int j = 0; j < 6; j++) begin wait_valid(v); ref_seq[j] = v; end
    restart(4'd0, 8'd3, 4'b0111);
    while (ce_cnt < 128) @(negedge clk);
    en = 1'b0;
    n = 0;
    repeat (8) begin
      @(negedge clk);
      if (pcm_valid === 1'b1 || sd_ce === 1'b1) n++;
    end
    chk("R9 no strobe or enable while idle", n, 0);
    chk("R9 pcm cleared while idle", pcm, 0);
    pat = 4'b0001; pidx = 0; ce_cnt = 0;
    en = 1'b1;
    for (int j = 0; j < 6; j++) begin
      wait_valid(v);
      chk($sformatf("R9 restart sample %0d", j), longint'(v), longint'(ref_seq[j]));
    end

    finish_run();
  end

endmodule